// File: doc/BRIEF.md
# Software interrupt acknowledge vector resolver

The block gathers a set of interrupt request lines. Each line has a fixed level from 1 to 7, a fixed priority within that level, and a 7-bit vector number. A source is pending when its hardware line or its software force bit is set, and its mask bit is clear.

On every clock cycle the block registers three results:
- the highest pending level, encoded on three bits;
- a global acknowledge vector, taken from the highest-level, highest-priority pending source;
- one acknowledge vector for each level, taken from the highest-priority pending source of that level alone.

Software reads and writes the mask and force registers through a simple byte-wide register port. The same port reads the acknowledge results, which are read-only.

Source i sits at level (i mod 7) + 1 and carries vector VEC_BASE + i, with VEC_BASE = 64 by default. Within a level, the lower source index has the higher priority. NUM_SRC must be a multiple of 8 and no larger than 64.

Top module: `irqv_resolver`

## Requirements
- R1: After reset, the mask and force registers read 0, the encoded level is 0, the global acknowledge reads 0 and every per-level acknowledge reads 24.
- R2: A source is pending exactly when (hardware line OR force bit) AND NOT mask bit. A masked source is excluded from every result, whatever its level.
- R3: The encoded level `irq_level` equals the highest level among pending sources, or 0 when none is pending. It reflects the inputs and registers one clock edge after they change.
- R4: The global acknowledge (address 0x10) returns VEC_BASE+i, where i is the pending source with the highest level and, within that level, the lowest index.
- R5: The global acknowledge returns 0 when no source is pending.
- R6: The per-level acknowledge for level L (address 0x10+L, L = 1..7) returns VEC_BASE+i of the lowest-index pending source at level L only.
- R7: A per-level acknowledge returns the spurious vector 24 when level L has no pending source.
- R8: Bit 7 of every acknowledge read is 0; bits 6..0 carry the vector.
- R9: Mask byte b is at address b and force byte b is at address NUM_SRC/8+b. Bit k of byte b controls source 8b+k, and a write is read back unchanged.
- R10: Writes to acknowledge addresses (0x10 to 0x17) have no effect on any register or result.
- R11: When several sources of one level are pending together, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_SRC | Hardware request lines, one per source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational from registered state) |
| irq_level | output | 3 | Highest pending level, 0 if none |

## Verification
- A wrong mask or force bit shows at the mask or force read-back address straight away. It shows in `irq_level` and the acknowledge reads one edge after the write takes effect.
- A faulty priority encoder returns the vector of a higher-index source, or a wrong level's vector, when several sources are pending together. The bench drives such overlaps within one level and across levels for this reason.
- A stale result register holds an old vector or level for one or more cycles after a request falls. The bench catches this by reading right after each change.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int          NUM_LEVELS   = 7;
    localparam int          VEC_W        = 7;
    localparam logic [6:0]  SPURIOUS_VEC = 7'd24;
    localparam logic [4:0]  ACK_BASE     = 5'h10;

    function automatic logic [2:0] src_level(input int idx);
        return 3'((idx % NUM_LEVELS) + 1);
    endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] force_q,
    output logic [7:0]         reg_rdata
);
    import irqv_pkg::*;

    localparam int NB = NUM_SRC / 8;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [NUM_SRC-1:0] frc;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        reg_rdata = 8'h00;
        for (int b = 0; b < NB; b++) begin
            if (addr == ADDR_W'(b)) begin
                reg_rdata = st_q.mask[b*8 +: 8];
                if (wr_en) st_d.mask[b*8 +: 8] = wdata;
            end
            if (addr == ADDR_W'(NB + b)) begin
                reg_rdata = st_q.frc[b*8 +: 8];
                if (wr_en) st_d.frc[b*8 +: 8] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q  = st_q.mask;
    assign force_q = st_q.frc;

    // R10
    ack_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr >= ACK_BASE) |=> $stable(st_q));
endmodule

// File: rtl/irqv_level_pick.sv
module irqv_level_pick #(
    parameter int         NUM_SRC  = 16,
    parameter int         VEC_BASE = 64,
    parameter logic [2:0] LVL      = 3'd1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    output logic               any,
    output logic [6:0]         vec
);
    import irqv_pkg::*;

    logic [NUM_SRC-1:0] grant;

    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        vec   = SPURIOUS_VEC;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!found && pend[i] && src_level(i) == LVL) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                vec      = 7'(VEC_BASE + i);
            end
        end
        any = found;
    end

    // R11
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/irqv_resolver.sv
module irqv_resolver #(
    parameter int NUM_SRC  = 16,
    parameter int VEC_BASE = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               wr_en,
    input  logic [4:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic [2:0]         irq_level
);
    import irqv_pkg::*;

    localparam int ADDR_W = 5;

    typedef struct packed {
        logic [2:0]            level;
        logic [6:0]            gvec;
        logic [6:0][6:0]       lvec;
    } res_t;

    logic [NUM_SRC-1:0] mask_q, force_q, pend;
    logic [7:0]         reg_rdata;
    logic [6:0]         lvl_any;
    logic [6:0][6:0]    lvl_vec;
    res_t               res_d, res_q;

    irqv_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .mask_q(mask_q), .force_q(force_q), .reg_rdata(reg_rdata)
    );

    assign pend = (irq_in | force_q) & ~mask_q;

    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        irqv_level_pick #(.NUM_SRC(NUM_SRC), .VEC_BASE(VEC_BASE), .LVL(3'(g + 1))) u_pick (
            .clk(clk), .rst_n(rst_n), .pend(pend),
            .any(lvl_any[g]), .vec(lvl_vec[g])
        );

        // R7
        empty_level_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !lvl_any[g] |=> (res_q.lvec[g] == SPURIOUS_VEC));
    end

    always_comb begin
        res_d       = res_q;
        res_d.level = 3'd0;
        res_d.gvec  = 7'd0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            res_d.lvec[l] = lvl_any[l] ? lvl_vec[l] : SPURIOUS_VEC;
            if (lvl_any[l]) begin
                res_d.level = 3'(l + 1);
                res_d.gvec  = lvl_vec[l];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q.level <= 3'd0;
            res_q.gvec  <= 7'd0;
            for (int l = 0; l < NUM_LEVELS; l++) res_q.lvec[l] <= SPURIOUS_VEC;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        rdata = reg_rdata;
        if (addr == ACK_BASE) begin
            rdata = {1'b0, res_q.gvec};
        end else begin
            for (int l = 0; l < NUM_LEVELS; l++) begin
                if (addr == ACK_BASE + 5'(l + 1)) rdata = {1'b0, res_q.lvec[l]};
            end
        end
    end

    assign irq_level = res_q.level;

    // R3
    level_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> (irq_level != 3'd0));

    // R5
    global_zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level == 3'd0) == (res_q.gvec == 7'd0));

    // R8
    ack_bit7_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ACK_BASE) |-> !rdata[7]);
endmodule

// File: tb/tb_irqv_resolver.sv
`timescale 1ns/100ps
module tb_irqv_resolver;
    localparam int NS = 16;
    localparam int VB = 64;
    localparam int NB = NS / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    addr = 5'h1f;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic [2:0]    irq_level;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [NS-1:0] m_mask = '0;
    logic [NS-1:0] m_frc  = '0;

    irqv_resolver #(.NUM_SRC(NS), .VEC_BASE(VB)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_level(irq_level)
    );

    always #2.5 clk = ~clk;

    function automatic int lvl_of(int i); return (i % 7) + 1; endfunction
    function automatic logic [NS-1:0] pend_m();
        return (irq_in | m_frc) & ~m_mask;
    endfunction
    function automatic int exp_lvec(int l);
        logic [NS-1:0] p = pend_m();
        for (int i = 0; i < NS; i++) if (p[i] && lvl_of(i) == l) return VB + i;
        return 24;
    endfunction
    function automatic int exp_level();
        for (int l = 7; l >= 1; l--) if (exp_lvec(l) != 24) return l;
        return 0;
    endfunction
    function automatic int exp_gvec();
        int l = exp_level();
        return (l == 0) ? 0 : exp_lvec(l);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check_all(string req);
        int v;
        chk({req, " level"}, int'(irq_level), exp_level());
        rd(5'h10, v); chk({req, " global"}, v, exp_gvec());
        for (int l = 1; l <= 7; l++) begin
            rd(5'(16 + l), v); chk({req, " per-level"}, v, exp_lvec(l));
        end
    endtask

    task automatic t_reset();
        int v;
        for (int b = 0; b < 2 * NB; b++) begin
            rd(5'(b), v); chk("R1 reg reset", v, 0);
        end
        chk("R1 level", int'(irq_level), 0);
        rd(5'h10, v); chk("R5 global idle", v, 0);
        for (int l = 1; l <= 7; l++) begin
            rd(5'(16 + l), v); chk("R7 spurious", v, 24);
        end
    endtask

    task automatic t_single();
        for (int i = 0; i < NS; i++) begin
            irq_in = '0; irq_in[i] = 1'b1;
            settle();
            check_all("R3 R4 R6 single");
        end
        irq_in = '0; settle();
        check_all("R5 R7 idle");
    endtask

    task automatic t_priority();
        int v;
        irq_in = '0; irq_in[0] = 1'b1; irq_in[7] = 1'b1; irq_in[14] = 1'b1;
        settle();
        rd(5'h11, v); chk("R11 lvl1 three", v, 64);
        rd(5'h10, v); chk("R11 global", v, 64);
        irq_in[0] = 1'b0; settle();
        rd(5'h11, v); chk("R11 lvl1 two", v, 71);
        irq_in = '0; irq_in[2] = 1'b1; irq_in[9] = 1'b1; settle();
        rd(5'h13, v); chk("R11 lvl3", v, 66);
        check_all("R11 combo");
        irq_in = '0; settle();
    endtask

    task automatic t_multi();
        int v;
        irq_in = '0; irq_in[1] = 1'b1; irq_in[13] = 1'b1; irq_in[5] = 1'b1;
        settle();
        chk("R3 level7", int'(irq_level), 7);
        rd(5'h10, v); chk("R4 global lvl7", v, 77);
        wr(5'h01, 8'h20); m_mask = 16'h2000;
        settle();
        chk("R2 masked level", int'(irq_level), 6);
        rd(5'h10, v); chk("R2 masked global", v, 69);
        rd(5'h17, v); chk("R7 masked lvl7", v, 24);
        rd(5'h12, v); chk("R6 lvl2", v, 65);
        check_all("R2 R6 multi");
        wr(5'h01, 8'h00); m_mask = '0;
        irq_in = '0; settle();
    endtask

    task automatic t_force();
        int v;
        wr(5'(NB), 8'h08); m_frc = 16'h0008;
        settle();
        chk("R2 forced level", int'(irq_level), 4);
        rd(5'h10, v); chk("R2 forced global", v, 67);
        wr(5'h00, 8'h08); m_mask = 16'h0008;
        settle();
        chk("R2 forced masked level", int'(irq_level), 0);
        rd(5'h10, v); chk("R5 forced masked global", v, 0);
        rd(5'h14, v); chk("R7 forced masked lvl4", v, 24);
        wr(5'h00, 8'h00); m_mask = '0;
        settle();
    endtask

    task automatic t_ro();
        int v;
        wr(5'h10, 8'hFF);
        wr(5'h14, 8'hFF);
        wr(5'h17, 8'hFF);
        settle();
        rd(5'h10, v); chk("R10 global after write", v, 67);
        chk("R8 bit7 global", (v >> 7) & 1, 0);
        rd(5'h14, v); chk("R10 lvl4 after write", v, 67);
        rd(5'h17, v); chk("R10 lvl7 after write", v, 24);
        chk("R8 bit7 lvl7", (v >> 7) & 1, 0);
        rd(5'h00, v); chk("R10 mask untouched", v, 0);
        rd(5'(NB), v); chk("R10 force untouched", v, 8);
        check_all("R10 state");
    endtask

    task automatic t_readback();
        int v;
        wr(5'h00, 8'hA5); wr(5'h01, 8'h3C);
        wr(5'(NB), 8'h5A); wr(5'(NB + 1), 8'hC3);
        m_mask = 16'h3CA5; m_frc = 16'hC35A;
        rd(5'h00, v); chk("R9 mask b0", v, 8'hA5);
        rd(5'h01, v); chk("R9 mask b1", v, 8'h3C);
        rd(5'(NB), v); chk("R9 force b0", v, 8'h5A);
        rd(5'(NB + 1), v); chk("R9 force b1", v, 8'hC3);
        settle();
        check_all("R2 R9 mixed");
        irq_in = 16'hFFFF; settle();
        check_all("R2 R4 all hw");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_priority();
        t_multi();
        t_force();
        t_ro();
        t_readback();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule